// File: doc/BRIEF.md
# Double-Buffered Serial Byte Datapath for a Two-Wire Bus Controller

This block is the byte-wide data path that sits between a processor and the serial data line of a two-wire (I2C) bus controller. The processor writes outgoing bytes into a holding buffer. When the internal shift register is idle, the held byte is copied into it automatically, and the holding buffer is then free for the next byte. An external bus sequencer supplies a direction input and a one-cycle shift strobe for each bit period. In transmit, each strobe moves the next bit onto the serial output. In receive, each strobe samples the serial input. After eight strobes a completed received byte is handed to a read-only receive buffer.

A holding buffer that refills the shift register at the same edge as the last bit lets consecutive bytes leave with no idle bit period between them. A bit-order input selects most-significant-first or least-significant-first traffic. Bit order is applied when a byte enters the transmit buffer and when a byte leaves the shift register for the receive buffer. Start and stop conditions, arbitration, acknowledge, clock generation and pad drivers belong to the surrounding controller.

Top module: `i2c_byte_datapath`

## Requirements
- R1: Reset state: transmit buffer and receive buffer both read 0xFF, tx_empty is 1, rx_full is 0, overrun is 0 and sda_out is 1.
- R2: A write strobe stores the written byte in the transmit buffer and clears tx_empty on the next edge. With lsb_first at 1, the byte is stored bit-reversed (bit i moves to bit 7-i), and tx_buf_q returns that reversed value.
- R3: With dir_tx at 1, the shift register idle and tx_empty at 0, the next edge copies the transmit buffer into the shift register and sets tx_empty. sda_out then presents bit 7 of the stored value.
- R4: Each transmit-direction shift strobe advances the output, so sda_out shows the stored value from bit 7 down to bit 0. After the eighth strobe, sda_out returns to 1 unless a new byte was waiting.
- R5: If a byte is waiting when the eighth transmit strobe occurs, it is loaded at that same edge, and its bit 7 appears on sda_out in the very next cycle. A write in the same cycle as a copy leaves the new byte pending, with tx_empty at 0.
- R6: byte_done is 1 only while the strobe that completes the eighth bit is present. Transmit-direction strobes with no byte loaded have no effect on the bit count or on sda_out.
- R7: With dir_tx at 0, each strobe samples sda_in. After the eighth strobe, the receive buffer holds the byte and rx_full is 1. The first sampled bit becomes bit 7 when lsb_first is 0, and bit 0 when lsb_first is 1.
- R8: A read strobe clears rx_full. A read in the same cycle as a receive completion leaves rx_full at 1 for the new byte.
- R9: A receive completion while rx_full is 1 and no read is present overwrites the receive buffer and sets overrun. Overrun stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lsb_first | input | 1 | 1 = least-significant bit first on the wire |
| dir_tx | input | 1 | 1 = transmit, 0 = receive |
| cpu_wr_tx | input | 1 | Write strobe for the transmit buffer |
| cpu_wdata | input | DATA_W | Byte written to the transmit buffer |
| cpu_rd_rx | input | 1 | Read strobe for the receive buffer |
| shift_stb | input | 1 | One-cycle bit strobe from the bus sequencer |
| sda_in | input | 1 | Sampled serial data line |
| tx_buf_q | output | DATA_W | Transmit buffer contents |
| rx_buf_q | output | DATA_W | Receive buffer contents |
| tx_empty | output | 1 | Transmit buffer has been taken by the shift register |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| overrun | output | 1 | Sticky: an unread byte was overwritten |
| byte_done | output | 1 | Strobe of the eighth bit |
| sda_out | output | 1 | Serial data to drive (1 = release) |

## Verification
Two pairs of functions can fall in the same clock. In the first pair, the processor writes while the held byte is being copied into the shift register. The bench provokes this by issuing a second write one cycle after the first, in the copy cycle. It then judges that the first byte is shifted out, that the second byte stays pending, and that this second byte follows the first with no gap. In the second pair, a processor read coincides with a receive completion. The bench raises the read strobe together with the eighth strobe of a second unread byte, and expects rx_full to stay at 1 with the new byte and no overrun.

// File: rtl/i2c_bdp_pkg.sv
package i2c_bdp_pkg;
   typedef enum logic {
      BDP_DIR_RX = 1'b0,
      BDP_DIR_TX = 1'b1
   } bdp_dir_e;

   // Level driven on the serial output when nothing is being sent
   localparam logic BDP_LINE_IDLE = 1'b1;

   // Smallest word the shifter can serialise
   localparam int BDP_MIN_W = 2;
endpackage

// File: rtl/bdp_bit_order.sv
module bdp_bit_order #(
   parameter int W = 8
) (
   input  logic         rev,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] flipped;

   for (genvar i = 0; i < W; i++) begin : g_flip
      assign flipped[i] = d[W-1-i];
   end

   assign q = rev ? flipped : d;
endmodule

// File: rtl/bdp_bit_counter.sv
module bdp_bit_counter #(
   parameter int W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic at_last
);
   localparam int CW = (W > 1) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [CW-1:0] cnt;

   assign at_last = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (adv) begin
         cnt <= at_last ? '0 : cnt + CW'(1);
      end
   end
endmodule

// File: rtl/bdp_tx_hold.sv
module bdp_tx_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         take,
   output logic [W-1:0] q,
   output logic         empty
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q     <= '1;
         empty <= 1'b1;
      end else if (wr) begin
         q     <= wdata;
         empty <= 1'b0;
      end else if (take) begin
         empty <= 1'b1;
      end
   end
endmodule

// File: rtl/bdp_rx_hold.sv
module bdp_rx_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] ldata,
   input  logic         rd,
   output logic [W-1:0] q,
   output logic         full,
   output logic         overrun
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q       <= '1;
         full    <= 1'b0;
         overrun <= 1'b0;
      end else if (load) begin
         q    <= ldata;
         full <= 1'b1;
         if (full && !rd) begin
            overrun <= 1'b1;
         end
      end else if (rd) begin
         full <= 1'b0;
      end
   end
endmodule

// File: rtl/bdp_shifter.sv
module bdp_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] ldata,
   input  logic         shift,
   input  logic         shift_bit,
   input  logic         finish,
   output logic [W-1:0] word,
   output logic         busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= '1;
         busy <= 1'b0;
      end else if (load) begin
         word <= ldata;
         busy <= 1'b1;
      end else if (shift) begin
         word <= {word[W-2:0], shift_bit};
         if (finish) begin
            busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/i2c_byte_datapath.sv
module i2c_byte_datapath
   import i2c_bdp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lsb_first,
   input  logic              dir_tx,
   input  logic              cpu_wr_tx,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_rd_rx,
   input  logic              shift_stb,
   input  logic              sda_in,
   output logic [DATA_W-1:0] tx_buf_q,
   output logic [DATA_W-1:0] rx_buf_q,
   output logic              tx_empty,
   output logic              rx_full,
   output logic              overrun,
   output logic              byte_done,
   output logic              sda_out
);
   if (DATA_W < BDP_MIN_W) begin : g_bad_width
      $error("i2c_byte_datapath: DATA_W must be at least %0d", BDP_MIN_W);
   end

   bdp_dir_e dir_now, dir_q;
   logic              sh_busy, at_last, tx_stb, rx_stb, adv, tx_start, bit_in;
   logic [DATA_W-1:0] sh_word, wdata_ord, rx_raw, rx_ord;

   assign dir_now = bdp_dir_e'(dir_tx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= BDP_DIR_RX;
      end else begin
         dir_q <= dir_now;
      end
   end

   assign tx_stb    = (dir_now == BDP_DIR_TX) && sh_busy && shift_stb;
   assign rx_stb    = (dir_now == BDP_DIR_RX) && shift_stb;
   assign adv       = tx_stb || rx_stb;
   assign byte_done = adv && at_last;
   assign tx_start  = (dir_now == BDP_DIR_TX) && !tx_empty &&
                      (!sh_busy || (tx_stb && at_last));
   assign bit_in    = (dir_now == BDP_DIR_TX) ? BDP_LINE_IDLE : sda_in;
   assign rx_raw    = {sh_word[DATA_W-2:0], sda_in};
   assign sda_out   = ((dir_now == BDP_DIR_TX) && sh_busy) ? sh_word[DATA_W-1]
                                                          : BDP_LINE_IDLE;

   bdp_bit_order #(.W(DATA_W)) u_order_tx (
      .rev (lsb_first),
      .d   (cpu_wdata),
      .q   (wdata_ord)
   );

   bdp_bit_order #(.W(DATA_W)) u_order_rx (
      .rev (lsb_first),
      .d   (rx_raw),
      .q   (rx_ord)
   );

   bdp_bit_counter #(.W(DATA_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (dir_now != dir_q),
      .adv     (adv),
      .at_last (at_last)
   );

   bdp_tx_hold #(.W(DATA_W)) u_tx_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cpu_wr_tx),
      .wdata (wdata_ord),
      .take  (tx_start),
      .q     (tx_buf_q),
      .empty (tx_empty)
   );

   bdp_shifter #(.W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tx_start),
      .ldata     (tx_buf_q),
      .shift     (adv),
      .shift_bit (bit_in),
      .finish    (tx_stb && at_last),
      .word      (sh_word),
      .busy      (sh_busy)
   );

   bdp_rx_hold #(.W(DATA_W)) u_rx_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (byte_done && (dir_now == BDP_DIR_RX)),
      .ldata   (rx_ord),
      .rd      (cpu_rd_rx),
      .q       (rx_buf_q),
      .full    (rx_full),
      .overrun (overrun)
   );
endmodule

// File: rtl/i2c_byte_datapath_chk.sv
module i2c_byte_datapath_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lsb_first,
   input logic              dir_tx,
   input logic              cpu_wr_tx,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic              cpu_rd_rx,
   input logic              shift_stb,
   input logic              sda_in,
   input logic [DATA_W-1:0] tx_buf_q,
   input logic [DATA_W-1:0] rx_buf_q,
   input logic              tx_empty,
   input logic              rx_full,
   input logic              overrun,
   input logic              byte_done,
   input logic              sda_out
);
   function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
      logic [DATA_W-1:0] r;
      for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
      return r;
   endfunction

   assert_write_clears_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr_tx |=> !tx_empty);

   assert_write_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr_tx |=> tx_buf_q == ($past(lsb_first) ? flip($past(cpu_wdata)) : $past(cpu_wdata)));

   assert_rx_line_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_tx |-> sda_out);

   assert_done_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> shift_stb);

   assert_rx_sets_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !dir_tx) |=> rx_full);

   assert_last_bit_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !dir_tx && !lsb_first) |=> rx_buf_q[0] == $past(sda_in));

   assert_read_clears_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd_rx && !(byte_done && !dir_tx)) |=> !rx_full);

   assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(rx_full));

   assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
endmodule

bind i2c_byte_datapath i2c_byte_datapath_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lsb_first (lsb_first),
   .dir_tx    (dir_tx),
   .cpu_wr_tx (cpu_wr_tx),
   .cpu_wdata (cpu_wdata),
   .cpu_rd_rx (cpu_rd_rx),
   .shift_stb (shift_stb),
   .sda_in    (sda_in),
   .tx_buf_q  (tx_buf_q),
   .rx_buf_q  (rx_buf_q),
   .tx_empty  (tx_empty),
   .rx_full   (rx_full),
   .overrun   (overrun),
   .byte_done (byte_done),
   .sda_out   (sda_out)
);

// File: tb/i2c_byte_datapath_bench.sv
module i2c_byte_datapath_bench;
   logic       clk = 1'b0;
   logic       rst_n, lsb_first, dir_tx, cpu_wr_tx, cpu_rd_rx, shift_stb, sda_in;
   logic [7:0] cpu_wdata, tx_buf_q, rx_buf_q;
   logic       tx_empty, rx_full, overrun, byte_done, sda_out;
   int         n_chk = 0;
   int         n_fail = 0;

   always #10 clk = ~clk;

   // {lsb_first, written byte, expected stored / wire-order byte}
   localparam logic [16:0] VEC [0:5] = '{
      {1'b0, 8'hA5, 8'hA5},
      {1'b1, 8'h01, 8'h80},
      {1'b1, 8'hC8, 8'h13},
      {1'b0, 8'h00, 8'h00},
      {1'b1, 8'hF0, 8'h0F},
      {1'b0, 8'h5A, 8'h5A}
   };

   i2c_byte_datapath #(.DATA_W(8)) u_i2c_byte_datapath (
      .clk, .rst_n, .lsb_first, .dir_tx, .cpu_wr_tx, .cpu_wdata, .cpu_rd_rx,
      .shift_stb, .sda_in, .tx_buf_q, .rx_buf_q, .tx_empty, .rx_full,
      .overrun, .byte_done, .sda_out
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic strobe(input logic b);
      sda_in = b; shift_stb = 1'b1;
      tick();
      shift_stb = 1'b0;
   endtask

   task automatic write_tx(input logic [7:0] d);
      cpu_wr_tx = 1'b1; cpu_wdata = d;
      tick();
      cpu_wr_tx = 1'b0;
   endtask

   task automatic read_rx();
      cpu_rd_rx = 1'b1;
      tick();
      cpu_rd_rx = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   // shift a loaded byte out, checking every bit and the done pulse
   task automatic send_check(input logic [7:0] exp_word, input string req);
      for (int b = 7; b >= 0; b--) begin
         chk(req, sda_out, exp_word[b]);
         shift_stb = 1'b1;
         #1;
         chk("R6 byte_done", byte_done, (b == 0));
         tick();
         shift_stb = 1'b0;
      end
   endtask

   task automatic recv(input logic [7:0] wire_word);
      for (int b = 7; b >= 0; b--) strobe(wire_word[b]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; lsb_first = 1'b0; dir_tx = 1'b0; cpu_wr_tx = 1'b0;
      cpu_rd_rx = 1'b0; shift_stb = 1'b0; sda_in = 1'b1; cpu_wdata = '0;
      @(negedge clk);
      do_reset();

      // R1 reset state
      chk("R1 tx_buf", tx_buf_q, 8'hFF);
      chk("R1 rx_buf", rx_buf_q, 8'hFF);
      chk("R1 tx_empty", tx_empty, 1);
      chk("R1 rx_full", rx_full, 0);
      chk("R1 overrun", overrun, 0);
      chk("R1 sda_out", sda_out, 1);

      // vector walk: transmit then loop the wire order back as receive
      for (int v = 0; v < 6; v++) begin
         logic       mode;
         logic [7:0] data, stored;
         {mode, data, stored} = VEC[v];
         lsb_first = mode; dir_tx = 1'b1;
         tick();
         write_tx(data);
         chk("R2 readback", tx_buf_q, stored);
         chk("R2 tx_empty", tx_empty, 0);
         tick();
         chk("R3 tx_empty", tx_empty, 1);
         send_check(stored, "R4 sda_out bit");
         chk("R4 idle after byte", sda_out, 1);
         dir_tx = 1'b0;
         tick();
         recv(stored);
         chk("R7 rx_buf", rx_buf_q, data);
         chk("R7 rx_full", rx_full, 1);
         read_rx();
         chk("R8 rx_full cleared", rx_full, 0);
         chk("R9 no overrun", overrun, 0);
      end

      // R6: transmit strobes with nothing loaded are ignored
      lsb_first = 1'b0; dir_tx = 1'b1;
      tick();
      for (int i = 0; i < 3; i++) begin
         shift_stb = 1'b1;
         #1;
         chk("R6 idle strobe no done", byte_done, 0);
         tick();
         shift_stb = 1'b0;
         chk("R6 idle strobe sda", sda_out, 1);
      end
      write_tx(8'hC3);
      tick();
      send_check(8'hC3, "R6 full byte after idle strobes");

      // R5: write during the copy cycle, then gapless refill
      cpu_wr_tx = 1'b1; cpu_wdata = 8'h81;
      tick();
      cpu_wdata = 8'h7E;
      tick();
      cpu_wr_tx = 1'b0;
      chk("R5 pending after copy", tx_empty, 0);
      chk("R5 pending byte", tx_buf_q, 8'h7E);
      send_check(8'h81, "R5 first byte bit");
      chk("R5 refilled", tx_empty, 1);
      send_check(8'h7E, "R5 second byte bit");
      chk("R5 idle after pair", sda_out, 1);

      // R9: overrun on an unread byte, then sticky
      dir_tx = 1'b0;
      tick();
      recv(8'h11);
      recv(8'h22);
      chk("R9 overwritten", rx_buf_q, 8'h22);
      chk("R9 overrun set", overrun, 1);
      read_rx();
      chk("R9 overrun sticky", overrun, 1);

      // R8: read in the completion cycle
      do_reset();
      recv(8'h33);
      for (int b = 7; b >= 1; b--) strobe(8'h44 >> b);
      sda_in = 1'b0; shift_stb = 1'b1; cpu_rd_rx = 1'b1;
      tick();
      shift_stb = 1'b0; cpu_rd_rx = 1'b0;
      chk("R8 full kept", rx_full, 1);
      chk("R8 no overrun", overrun, 0);
      chk("R7 new byte", rx_buf_q, 8'h44);
      read_rx();
      chk("R8 cleared", rx_full, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule